// File: doc/BRIEF.md
# Reset Pin Supervisor

This block manages a shared, open-drain, active-low reset line. When asked, it pulls the line low for a fixed number of timebase ticks. A single select input chooses between a short pulse and a long pulse. While it is not driving, it treats any sustained low level on the line as a reset applied by another agent and reports it to the system mode controller. Very short lows are dropped as glitches.

The block also checks that the line follows its drive. If the line stays low too long after the block has let go, the block asks the mode controller for fail-safe operation. If the line stays high while the block is pulling it low, the block raises a sticky clamped-high flag, which remains set until it is cleared. All timing is counted in ticks of an external timebase. The raw pin level passes through a two-flop synchronizer before any timing decision is made.

Top module: `rst_pin_supervisor`

## Requirements
- R1: After synchronous reset, the pin drive, the external-reset pulse, the fail-safe pulse and the clamped-high flag are all 0.
- R2: A request accepted while the block is idle drives the pin low (pin_drive_o = 1) for SHORT_TICKS ticks when pulse_long_i was 0 at the request, and LONG_TICKS ticks when it was 1. A later change of pulse_long_i does not alter a pulse that is already running.
- R3: A request that arrives while a pulse is running, or while the block is still watching the line after a pulse, is ignored: it neither lengthens the pulse nor starts a second one. The pin is driven only after a request.
- R4: A low on the line that the block did not drive, and that lasts GLITCH_TICKS ticks, produces exactly one ext_rst_o pulse. The block then waits for the line to return high before it can report again.
- R5: ext_rst_o and failsafe_o are each high for exactly one clock cycle per event.
- R6: An undriven low that returns high before GLITCH_TICKS ticks produces no ext_rst_o pulse.
- R7: If the line is still low CLAMP_LO_TICKS ticks after the block releases it, failsafe_o pulses once. That low episode is never also reported on ext_rst_o.
- R8: A low that persists after release but goes high before CLAMP_LO_TICKS ticks produces neither a fail-safe nor an external-reset pulse.
- R9: If the synchronized line stays high for CLAMP_HI_TICKS consecutive ticks while the block drives it low, clamp_hi_o is set.
- R10: clamp_hi_o stays set until hi_clr_i is asserted, and it reads 0 in the cycle after the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| pin_i | input | 1 | Raw level read back from the reset line (1 = high) |
| pulse_long_i | input | 1 | Pulse length select: 0 short, 1 long |
| pulse_req_i | input | 1 | Request for a reset pulse |
| hi_clr_i | input | 1 | Clears the clamped-high flag |
| pin_drive_o | output | 1 | 1 = pull the reset line low |
| ext_rst_o | output | 1 | One-cycle pulse: external reset detected |
| failsafe_o | output | 1 | One-cycle pulse: line held low after release |
| clamp_hi_o | output | 1 | Sticky flag: line stayed high while driven low |

## Verification
The bench builds the block with SHORT_TICKS=4, LONG_TICKS=16, GLITCH_TICKS=3, CLAMP_LO_TICKS=8 and CLAMP_HI_TICKS=3, and it issues a tick every fourth clock. These small limits keep every fault scenario, including the stuck-low wait and the long pulse, within a few hundred cycles. At the same time, the cycle windows of the short pulse (13 to 16 cycles) and the long pulse (61 to 64 cycles) stay disjoint, so a measured pulse can be assigned to one length without doubt. The bench models the line as a wired-AND of the block's drive with an external pull and two stuck-fault switches. This lets it reach glitches, genuine external resets, lows that outlast release and a line clamped high.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRIVE = 3'd1,
    ST_WATCH = 3'd2,
    ST_EXTLO = 3'd3,
    ST_HOLD  = 3'd4
  } rsp_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= RESET_VAL;
          else     chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= RESET_VAL;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rsp_seq.sv
module rsp_seq
  import rsp_pkg::*;
#(
  parameter int SHORT_TICKS    = 8,
  parameter int LONG_TICKS     = 64,
  parameter int CLAMP_LO_TICKS = 32,
  parameter int GLITCH_TICKS   = 4,
  parameter int CW             = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pin_s_i,
  input  logic long_sel_i,
  input  logic req_i,
  output logic drive_o,
  output logic ext_o,
  output logic fs_o
);

  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] LO_LAST    = CW'(CLAMP_LO_TICKS - 1);
  localparam logic [CW-1:0] GL_LAST    = CW'(GLITCH_TICKS - 1);

  rsp_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic          drive_q, ext_q, fs_q;
  logic [CW-1:0] drive_last;

  assign drive_last = long_q ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      long_q  <= 1'b0;
      drive_q <= 1'b0;
      ext_q   <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      ext_q <= 1'b0;
      fs_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (req_i) begin
            state_q <= ST_DRIVE;
            long_q  <= long_sel_i;
            drive_q <= 1'b1;
          end else if (!pin_s_i) begin
            state_q <= ST_EXTLO;
          end
        end
        ST_DRIVE: begin
          if (tick_i) begin
            if (cnt_q == drive_last) begin
              state_q <= ST_WATCH;
              cnt_q   <= '0;
              drive_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_WATCH: begin
          if (pin_s_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else if (tick_i) begin
            if (cnt_q == LO_LAST) begin
              fs_q    <= 1'b1;
              state_q <= ST_HOLD;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_EXTLO: begin
          if (pin_s_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else if (tick_i) begin
            if (cnt_q == GL_LAST) begin
              ext_q   <= 1'b1;
              state_q <= ST_HOLD;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          cnt_q <= '0;
          if (pin_s_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_o = drive_q;
  assign ext_o   = ext_q;
  assign fs_o    = fs_q;

  // R3
  drive_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_o) |-> $past(req_i));

  // R5
  ext_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ext_o |=> !ext_o);

  // R5
  fs_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    fs_o |=> !fs_o);

  // R4
  ext_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    ext_o |-> ($past(!pin_s_i) && !drive_o));

  // R7
  fs_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    fs_o |-> ($past(!pin_s_i) && !drive_o));

endmodule

// File: rtl/rsp_hi_mon.sv
module rsp_hi_mon #(
  parameter int CLAMP_HI_TICKS = 4,
  parameter int CW             = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic drive_i,
  input  logic pin_s_i,
  input  logic clr_i,
  output logic flag_o
);

  localparam logic [CW-1:0] HI_LAST = CW'(CLAMP_HI_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          hit;

  assign hit = drive_i && pin_s_i && tick_i && (cnt_q == HI_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (!drive_i || !pin_s_i)  cnt_q <= '0;
      else if (hit)              cnt_q <= '0;
      else if (tick_i)           cnt_q <= cnt_q + 1'b1;

      if (clr_i)    flag_q <= 1'b0;
      else if (hit) flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R9
  flag_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(drive_i && pin_s_i && tick_i));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !flag_o);

endmodule

// File: rtl/rst_pin_supervisor.sv
module rst_pin_supervisor
  import rsp_pkg::*;
#(
  parameter int SHORT_TICKS    = 8,
  parameter int LONG_TICKS     = 64,
  parameter int CLAMP_LO_TICKS = 32,
  parameter int CLAMP_HI_TICKS = 4,
  parameter int GLITCH_TICKS   = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic pin_i,
  input  logic pulse_long_i,
  input  logic pulse_req_i,
  input  logic hi_clr_i,
  output logic pin_drive_o,
  output logic ext_rst_o,
  output logic failsafe_o,
  output logic clamp_hi_o
);

  localparam int MAX_T = max2(max2(max2(SHORT_TICKS, LONG_TICKS),
                                   max2(CLAMP_LO_TICKS, CLAMP_HI_TICKS)),
                              GLITCH_TICKS);
  localparam int CW = $clog2(MAX_T + 1);

  logic pin_s;
  logic drive;

  rsp_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) sync_i (
    .clk(clk),
    .rst(rst),
    .d_i(pin_i),
    .q_o(pin_s)
  );

  rsp_seq #(
    .SHORT_TICKS   (SHORT_TICKS),
    .LONG_TICKS    (LONG_TICKS),
    .CLAMP_LO_TICKS(CLAMP_LO_TICKS),
    .GLITCH_TICKS  (GLITCH_TICKS),
    .CW            (CW)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .pin_s_i   (pin_s),
    .long_sel_i(pulse_long_i),
    .req_i     (pulse_req_i),
    .drive_o   (drive),
    .ext_o     (ext_rst_o),
    .fs_o      (failsafe_o)
  );

  rsp_hi_mon #(
    .CLAMP_HI_TICKS(CLAMP_HI_TICKS),
    .CW            (CW)
  ) hi_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .drive_i(drive),
    .pin_s_i(pin_s),
    .clr_i  (hi_clr_i),
    .flag_o (clamp_hi_o)
  );

  assign pin_drive_o = drive;

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!pin_drive_o && !ext_rst_o && !failsafe_o && !clamp_hi_o));

endmodule

// File: tb/rst_pin_supervisor_tb_top.sv
module rst_pin_supervisor_tb_top;

  localparam int EV_SHORT = 1;
  localparam int EV_LONG  = 2;
  localparam int EV_EXT   = 3;
  localparam int EV_FS    = 4;
  localparam int EV_HI    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic pulse_long = 1'b0;
  logic pulse_req = 1'b0;
  logic hi_clr = 1'b0;
  logic ext_pull = 1'b0;
  logic stuck_lo = 1'b0;
  logic stuck_hi = 1'b0;
  logic pin;
  logic pin_drive, ext_rst, failsafe, clamp_hi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  assign pin = stuck_hi ? 1'b1 : ~(pin_drive | ext_pull | stuck_lo);

  rst_pin_supervisor #(
    .SHORT_TICKS   (4),
    .LONG_TICKS    (16),
    .CLAMP_LO_TICKS(8),
    .CLAMP_HI_TICKS(3),
    .GLITCH_TICKS  (3),
    .SYNC_STAGES   (2)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .pin_i       (pin),
    .pulse_long_i(pulse_long),
    .pulse_req_i (pulse_req),
    .hi_clr_i    (hi_clr),
    .pin_drive_o (pin_drive),
    .ext_rst_o   (ext_rst),
    .failsafe_o  (failsafe),
    .clamp_hi_o  (clamp_hi)
  );

  // tick generator: one tick every fourth cycle, changed at falling edges
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % 4;
      tick = (tc == 0);
    end
  end

  function automatic string tag_of(input int code);
    case (code)
      EV_SHORT: return "R2 short pulse";
      EV_LONG:  return "R2 long pulse";
      EV_EXT:   return "R4 external reset";
      EV_FS:    return "R7 fail-safe";
      EV_HI:    return "R9 clamped-high";
      default:  return "R3 bad pulse length";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic got(input int code);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s: actual event %0d expected none (R3/R6/R8)", tag_of(code), code);
    end else begin
      int e = exp_q.pop_front();
      if (e != code) begin
        errors++;
        $display("FAIL %s: actual event %0d expected %0d", tag_of(e), code, e);
      end
    end
  endtask

  // monitor: classifies what the design produces and scores it
  initial begin
    bit p_drive = 0, p_ext = 0, p_fs = 0, p_hi = 0;
    int dcnt = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        p_drive = 0; p_ext = 0; p_fs = 0; p_hi = 0; dcnt = 0;
      end else begin
        if (pin_drive) dcnt++;
        if (p_drive && !pin_drive) begin
          if (dcnt >= 13 && dcnt <= 16)      got(EV_SHORT);
          else if (dcnt >= 61 && dcnt <= 64) got(EV_LONG);
          else                               got(9);
          dcnt = 0;
        end
        if (ext_rst) got(EV_EXT);
        if (ext_rst && p_ext) check(1'b0, "R5 ext pulse width", 2, 1);
        if (failsafe) got(EV_FS);
        if (failsafe && p_fs) check(1'b0, "R5 fail-safe pulse width", 2, 1);
        if (clamp_hi && !p_hi) got(EV_HI);
        p_drive = pin_drive; p_ext = ext_rst; p_fs = failsafe; p_hi = clamp_hi;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(input bit long_sel);
    @(negedge clk);
    pulse_req  = 1'b1;
    pulse_long = long_sel;
    @(negedge clk);
    pulse_req  = 1'b0;
  endtask

  task automatic expect_drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    cycles(5);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pin_drive == 0, "R1 drive after reset", pin_drive, 0);
    check(ext_rst == 0,   "R1 ext after reset", ext_rst, 0);
    check(failsafe == 0,  "R1 fail-safe after reset", failsafe, 0);
    check(clamp_hi == 0,  "R1 flag after reset", clamp_hi, 0);

    // R2 short pulse
    exp_q.push_back(EV_SHORT);
    request(1'b0);
    check(pin_drive == 1, "R2 drive after request", pin_drive, 1);
    cycles(30);
    expect_drained("R2 short pulse seen");

    // R2 long pulse, select changed mid-pulse
    exp_q.push_back(EV_LONG);
    request(1'b1);
    cycles(3);
    pulse_long = 1'b0;
    cycles(75);
    expect_drained("R2 long pulse kept length");

    // R3 second request during pulse is ignored
    exp_q.push_back(EV_SHORT);
    request(1'b0);
    cycles(4);
    request(1'b1);
    cycles(40);
    expect_drained("R3 request during pulse");

    // R4 external reset detected once
    exp_q.push_back(EV_EXT);
    @(negedge clk); ext_pull = 1'b1;
    cycles(40);
    ext_pull = 1'b0;
    cycles(10);
    expect_drained("R4 external reset once");

    // R6 glitch ignored
    @(negedge clk); ext_pull = 1'b1;
    cycles(5);
    ext_pull = 1'b0;
    cycles(20);
    check(ext_rst == 0, "R6 glitch no pulse", ext_rst, 0);
    expect_drained("R6 glitch ignored");

    // R8 low after release ending before the limit
    exp_q.push_back(EV_SHORT);
    request(1'b0);
    cycles(6);
    ext_pull = 1'b1;
    while (pin_drive) @(negedge clk);
    cycles(12);
    ext_pull = 1'b0;
    cycles(20);
    expect_drained("R8 short low after release");

    // R7 stuck low after release
    exp_q.push_back(EV_SHORT);
    exp_q.push_back(EV_FS);
    request(1'b0);
    cycles(6);
    stuck_lo = 1'b1;
    while (pin_drive) @(negedge clk);
    cycles(50);
    expect_drained("R7 fail-safe raised");
    stuck_lo = 1'b0;
    cycles(30);
    expect_drained("R7 no external reset after fail-safe");

    // R9 line clamped high during a long pulse
    stuck_hi = 1'b1;
    exp_q.push_back(EV_HI);
    exp_q.push_back(EV_LONG);
    request(1'b1);
    cycles(75);
    stuck_hi = 1'b0;
    expect_drained("R9 clamped-high reported");
    cycles(20);
    // R10 flag sticky, then cleared
    check(clamp_hi == 1, "R10 flag held", clamp_hi, 1);
    @(negedge clk); hi_clr = 1'b1;
    @(negedge clk); hi_clr = 1'b0;
    check(clamp_hi == 0, "R10 flag cleared", clamp_hi, 0);

    // R9 normal pulse does not set the flag
    exp_q.push_back(EV_SHORT);
    request(1'b0);
    cycles(30);
    check(clamp_hi == 0, "R9 no flag on healthy line", clamp_hi, 0);
    expect_drained("R9 healthy pulse");

    cycles(10);
    expect_drained("R3 no stray events");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule